// File: doc/BRIEF.md
# Shared-Register Interrupt Aggregator

This block gathers a handful of interrupt request lines into one level-sensitive line for a parent interrupt controller. Each source has a status bit that latches on a rising edge of its request line, whether or not that source is enabled. Each source also has an enable bit. The output line stays high while any source is both latched and enabled. Software clears a status bit by writing 1 to it.

Software reaches the block through a plain 32-bit register port: a byte address, a write strobe, write data, and combinational read data. A compile-time layout parameter selects one of two register maps:

- **Combined layout:** one word at offset 0 holds both the enables and the status bits. This lets a single write change the enables and acknowledge pending events at the same time.
- **Split layout:** the enables and the status bits live in two separate words. A parameter decides which of the two sits at offset 0x4.

The implemented sources may start above bit 0. Source i sits at bit position SRC_SHIFT+i.

Top module: `irq_aggregator`

## Requirements
- R1: In the combined layout, the single register is at byte offset 0. Enable of source i is bit SRC_SHIFT+i and status of source i is bit SRC_SHIFT+i+16. Any other offset reads 0, and writes to it change nothing.
- R2: A status bit becomes 1 on the clock after a 0-to-1 transition of its request line, even when the source is disabled. A request held high does not set it again after it has been cleared.
- R3: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. In the combined layout, one write updates all enables and clears the selected status bits together.
- R4: When a clear and a new rising edge hit the same status bit in the same cycle, the bit ends up set.
- R5: Enable and status bits outside the implemented sources read as 0, and writing 1 to them has no effect.
- R6: `irq_out` is 1 in the cycle after the state holds any source with both status and enable set, and 0 in the cycle after no such source exists. It therefore lags every status or enable change by one clock.
- R7: In the split layout, enable of source i is bit SRC_SHIFT+i of the enable word and status of source i is bit SRC_SHIFT+i of the status word. The status word is at offset 0x4 and the enable word at 0x0 when STATUS_AT_HI is 1, and the two swap when it is 0.
- R8: Synchronous active-high reset clears all enables, all status bits and `irq_out`.
- R9: Writing all ones to the status field and then 0 to the enables leaves every readable bit at 0, and the zero write sets no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Request lines, already synchronous to clk |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_out | output | 1 | Registered level interrupt to the parent |

## Verification
The assertions assume that every request line is already synchronous to the clock. They also assume that a low request line can never produce an edge, so any cycle with a 0 request and a clear strobe must end with the bit cleared. The bench drives requests and register accesses only on the falling edge, so every edge sees stable values. Before a reset it returns the request lines to 0, so that no line is high with a reset edge-history and falsely read as a new event.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    typedef enum logic {
        LAYOUT_COMBINED = 1'b0,
        LAYOUT_SPLIT    = 1'b1
    } layout_e;

    localparam int REG_W      = 32;
    localparam int STS_OFFSET = 16;

    // Bit position of source 0 inside the status word.
    function automatic int sts_base(layout_e lay, int shift);
        return (lay == LAYOUT_COMBINED) ? shift + STS_OFFSET : shift;
    endfunction

    // Mask of bits that may read back non-zero on one register word.
    function automatic logic [REG_W-1:0] legal_mask(layout_e lay, int num, int shift);
        logic [REG_W-1:0] m;
        m = ((REG_W'(1) << num) - REG_W'(1)) << shift;
        if (lay == LAYOUT_COMBINED)
            m = m | (m << STS_OFFSET);
        return m;
    endfunction

endpackage

// File: rtl/irqagg_regmap.sv
module irqagg_regmap
    import irqagg_pkg::*;
#(
    parameter layout_e LAYOUT       = LAYOUT_COMBINED,
    parameter int      NUM_SRC      = 4,
    parameter int      SRC_SHIFT    = 2,
    parameter bit      STATUS_AT_HI = 1'b1,
    parameter int      ADDR_W       = 3
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               we_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic [NUM_SRC-1:0] en_q_i,
    input  logic [NUM_SRC-1:0] sts_q_i,
    output logic               en_we_o,
    output logic [NUM_SRC-1:0] en_val_o,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [REG_W-1:0]   rdata_o
);

    localparam int EN_BASE  = SRC_SHIFT;
    localparam int STS_BASE = sts_base(LAYOUT, SRC_SHIFT);
    localparam logic [ADDR_W-1:0] WORD0 = '0;
    localparam logic [ADDR_W-1:0] WORD1 = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] EN_ADDR =
        (LAYOUT == LAYOUT_SPLIT && !STATUS_AT_HI) ? WORD1 : WORD0;
    localparam logic [ADDR_W-1:0] STS_ADDR =
        (LAYOUT == LAYOUT_SPLIT && STATUS_AT_HI) ? WORD1 :
        (LAYOUT == LAYOUT_SPLIT) ? WORD0 : WORD0;

    logic hit_en, hit_sts;
    logic unused_wdata;

    assign hit_en       = (addr_i == EN_ADDR);
    assign hit_sts      = (addr_i == STS_ADDR);
    assign en_we_o      = we_i && hit_en;
    assign unused_wdata = ^wdata_i;

    always_comb begin
        en_val_o = '0;
        clr_o    = '0;
        rdata_o  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            en_val_o[i] = wdata_i[EN_BASE + i];
            if (we_i && hit_sts)
                clr_o[i] = wdata_i[STS_BASE + i];
            if (hit_en)
                rdata_o[EN_BASE + i] = en_q_i[i];
            if (hit_sts)
                rdata_o[STS_BASE + i] = sts_q_i[i];
        end
    end

endmodule

// File: rtl/irqagg_state.sv
module irqagg_state #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               en_we_i,
    input  logic [NUM_SRC-1:0] en_val_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] en_q_o,
    output logic [NUM_SRC-1:0] sts_q_o
);

    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] rise;

    assign rise = req_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            en_q_o  <= '0;
            sts_q_o <= '0;
        end else begin
            prev_q  <= req_i;
            if (en_we_i)
                en_q_o <= en_val_i;
            // new edge outranks a clear in the same cycle
            sts_q_o <= (sts_q_o & ~clr_i) | rise;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        assert_set_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(req_i[g]) |=> sts_q_o[g]);
        assert_clear_w1c_R3: assert property (@(posedge clk) disable iff (rst)
            (clr_i[g] && !req_i[g]) |=> !sts_q_o[g]);
        assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
            (!clr_i[g] && !req_i[g]) |=> $stable(sts_q_o[g]));
    end

endmodule

// File: rtl/irqagg_irq_out.sv
module irqagg_irq_out #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] sts_i,
    output logic               irq_o
);

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |(en_i & sts_i);
    end

    assert_irq_rises_R6: assert property (@(posedge clk) disable iff (rst)
        (|(en_i & sts_i)) |=> irq_o);
    assert_irq_drops_R6: assert property (@(posedge clk) disable iff (rst)
        !(|(en_i & sts_i)) |=> !irq_o);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter layout_e LAYOUT       = LAYOUT_COMBINED,
    parameter int      NUM_SRC      = 4,
    parameter int      SRC_SHIFT    = 2,
    parameter bit      STATUS_AT_HI = 1'b1,
    parameter int      ADDR_W       = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_out
);

    localparam logic [REG_W-1:0] LEGAL = legal_mask(LAYOUT, NUM_SRC, SRC_SHIFT);

    logic               en_we;
    logic [NUM_SRC-1:0] en_val, clr, en_q, sts_q;

    irqagg_regmap #(
        .LAYOUT(LAYOUT), .NUM_SRC(NUM_SRC), .SRC_SHIFT(SRC_SHIFT),
        .STATUS_AT_HI(STATUS_AT_HI), .ADDR_W(ADDR_W)
    ) u_regmap (
        .addr_i(reg_addr), .we_i(reg_we), .wdata_i(reg_wdata),
        .en_q_i(en_q), .sts_q_i(sts_q),
        .en_we_o(en_we), .en_val_o(en_val), .clr_o(clr), .rdata_o(reg_rdata)
    );

    irqagg_state #(.NUM_SRC(NUM_SRC)) u_state (
        .clk(clk), .rst(rst), .req_i(irq_req),
        .en_we_i(en_we), .en_val_i(en_val), .clr_i(clr),
        .en_q_o(en_q), .sts_q_o(sts_q)
    );

    irqagg_irq_out #(.NUM_SRC(NUM_SRC)) u_out (
        .clk(clk), .rst(rst), .en_i(en_q), .sts_i(sts_q), .irq_o(irq_out)
    );

    assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~LEGAL) == '0);

endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
    import irqagg_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] tag;
        logic [3:0]  req;
        logic        we;
        logic [2:0]  waddr;
        logic [31:0] wdata;
        logic [2:0]  raddr;
        logic [31:0] exp_rd;
        logic        exp_irq;
    } vec_t;

    // Combined layout, 4 sources at bit 2: enables 5:2, status 21:18.
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{"R2", 4'b0001, 1'b0, 3'd0, 32'h0000_0000, 3'd0, 32'h0004_0000, 1'b0},
        '{"R6", 4'b0001, 1'b1, 3'd0, 32'h0000_0004, 3'd0, 32'h0004_0004, 1'b1},
        '{"R3", 4'b0001, 1'b1, 3'd0, 32'h0004_0004, 3'd0, 32'h0000_0004, 1'b0},
        '{"R2", 4'b0000, 1'b0, 3'd0, 32'h0000_0000, 3'd0, 32'h0000_0004, 1'b0},
        '{"R1", 4'b1010, 1'b0, 3'd0, 32'h0000_0000, 3'd0, 32'h0028_0004, 1'b0},
        '{"R5", 4'b1010, 1'b1, 3'd0, 32'h0000_00FF, 3'd0, 32'h0028_003C, 1'b1},
        '{"R3", 4'b1010, 1'b1, 3'd0, 32'h0008_0000, 3'd0, 32'h0020_0000, 1'b0},
        '{"R9", 4'b1010, 1'b1, 3'd0, 32'hFFFF_0000, 3'd0, 32'h0000_0000, 1'b0},
        '{"R9", 4'b1010, 1'b1, 3'd0, 32'h0000_0000, 3'd0, 32'h0000_0000, 1'b0},
        '{"R2", 4'b0101, 1'b0, 3'd0, 32'h0000_0000, 3'd0, 32'h0014_0000, 1'b0},
        '{"R4", 4'b0111, 1'b1, 3'd0, 32'h000C_0000, 3'd0, 32'h0018_0000, 1'b0},
        '{"R1", 4'b0111, 1'b1, 3'd4, 32'hFFFF_FFFF, 3'd4, 32'h0000_0000, 1'b0},
        '{"R1", 4'b0111, 1'b0, 3'd0, 32'h0000_0000, 3'd0, 32'h0018_0000, 1'b0},
        '{"R5", 4'b0111, 1'b1, 3'd0, 32'hFFC0_0003, 3'd0, 32'h0018_0000, 1'b0},
        '{"R6", 4'b0111, 1'b1, 3'd0, 32'h0000_0008, 3'd0, 32'h0018_0008, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  req = '0;
    logic [2:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    logic [1:0]  s_req = '0;
    logic [2:0]  s_addr = '0;
    logic        s_we = 1'b0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata;
    logic        s_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst(rst), .irq_req(req), .reg_addr(addr), .reg_we(we),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(irq)
    );

    irq_aggregator #(
        .LAYOUT(LAYOUT_SPLIT), .NUM_SRC(2), .SRC_SHIFT(0), .STATUS_AT_HI(1'b1)
    ) u_split (
        .clk(clk), .rst(rst), .irq_req(s_req), .reg_addr(s_addr), .reg_we(s_we),
        .reg_wdata(s_wdata), .reg_rdata(s_rdata), .irq_out(s_irq)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // split DUT: one access, then one idle cycle so irq catches up
    task automatic s_op(input logic [1:0] r, input logic w,
                        input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        s_req = r; s_we = w; s_addr = a; s_wdata = d;
        @(negedge clk);
        s_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic s_read(input string tag, input logic [2:0] a, input logic [31:0] exp);
        s_addr = a;
        #1;
        check(tag, "split read", s_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        check("R8", "reset rdata", rdata, 32'h0);
        check("R8", "reset irq", {31'b0, irq}, 32'h0);
        check("R8", "reset split rdata", s_rdata, 32'h0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            req = VECS[k].req; we = VECS[k].we;
            addr = VECS[k].waddr; wdata = VECS[k].wdata;
            @(negedge clk);
            we = 1'b0; addr = VECS[k].raddr;
            @(negedge clk);
            check(string'(VECS[k].tag), $sformatf("vec %0d rdata", k), rdata, VECS[k].exp_rd);
            check(string'(VECS[k].tag), $sformatf("vec %0d irq", k), {31'b0, irq},
                  {31'b0, VECS[k].exp_irq});
        end

        // R6: output lags an enable change by one clock
        addr = 3'd0; we = 1'b1; wdata = 32'h0;
        @(negedge clk);
        we = 1'b0;
        check("R6", "irq one cycle after disable", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R6", "irq two cycles after disable", {31'b0, irq}, 32'h0);

        // R8: reset in the middle of a run clears pending status
        req = '0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8", "mid-run reset rdata", rdata, 32'h0);
        check("R8", "mid-run reset irq", {31'b0, irq}, 32'h0);

        // R7: split layout, enables at 0x0, status at 0x4, sources at bits 1:0
        s_op(2'b01, 1'b0, 3'd0, 32'h0);
        s_read("R7", 3'd4, 32'h0000_0001);
        s_read("R7", 3'd0, 32'h0000_0000);
        check("R7", "split irq disabled", {31'b0, s_irq}, 32'h0);
        s_op(2'b01, 1'b1, 3'd0, 32'hFFFF_FFFF);
        s_read("R5", 3'd0, 32'h0000_0003);
        check("R7", "split irq enabled", {31'b0, s_irq}, 32'h1);
        s_op(2'b01, 1'b1, 3'd4, 32'h0000_0000);
        s_read("R3", 3'd4, 32'h0000_0001);
        s_op(2'b01, 1'b1, 3'd4, 32'h0000_FFFF);
        s_read("R7", 3'd4, 32'h0000_0000);
        s_read("R7", 3'd0, 32'h0000_0003);
        check("R7", "split irq after clear", {31'b0, s_irq}, 32'h0);

        finish_run();
    end

endmodule